// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This block decides which interrupt a 16550-style serial port reports and drives its single interrupt line. Five sources compete. Receiver line errors have the highest priority. Then come the character timeout, received data, the transmitter-empty condition, and modem-status changes. The winning source is encoded into an identification byte that software reads. The data path (FIFOs, serializer, baud generator) stays outside. It delivers level flags, counts and event pulses to this unit.

The unit holds three pieces of state:
- the four-bit interrupt-enable value;
- the sticky overrun and break flags, which a line-status read clears;
- the hidden transmitter-empty-pending flag.

That flag is set when the transmitter drains, or when the enable register is written while the holding register is empty. A write to the holding register clears it. A read of the identification byte also clears it, but only if that read returned the transmitter-empty code. The identification byte and the interrupt line are registered. Both reflect the state the same edge produces, so every input takes effect exactly one clock later.

Top module: `uart_irq_ident`

## Requirements
- R1: When several sources are active, `iir_o[3:0]` reports only the highest one. The order, highest first, is: line status (0x6), character timeout (0xC), received data (0x4), transmitter empty (0x2), modem status (0x0). 0x1 means no source is active.
- R2: The line-status source is active when enable bit 2 is set and any of these is set: the sticky overrun flag, `parity_err_i`, `frame_err_i`, or the sticky break flag.
- R3: The character-timeout source is active when `rx_timeout_i` is high and enable bit 0 is set. It has no enable bit of its own.
- R4: The received-data source is active when enable bit 0 is set and `data_ready_i` is high, and either `fifo_en_i` is low or `rx_count_i >= rx_trig_i`.
- R5: The transmitter-empty-pending flag is set by a `tx_drain_i` pulse, or by `ier_we_i` while `thre_i` is high. It is cleared by `thr_we_i`, and a clear by `thr_we_i` wins over a set in the same cycle. The flag raises source 0x2 when enable bit 1 is set.
- R6: An `iir_rd_i` pulse clears the pending flag only when `iir_o[3:0]` is 0x2 at that moment. A read that shows any other code leaves the flag set.
- R7: The modem-status source is active when enable bit 3 is set and any bit of `msr_delta_i` is high.
- R8: `iir_o[7:6]` is 2'b11 when `fifo_en_i` is high and 2'b00 otherwise. `iir_o[5:4]` is always 0.
- R9: `irq_o` is high exactly when `iir_o[3:0]` is not 0x1.
- R10: Pulses on `ovr_set_i` and `brk_set_i` set sticky flags. An `lsr_rd_i` pulse clears both, unless a set arrives in the same cycle, in which case the set wins. `parity_err_i` and `frame_err_i` are plain levels, and a line-status read does not affect them.
- R11: `ier_we_i` stores `ier_wdata_i[3:0]`. Bits 7:4 are dropped. `ier_o` returns the stored value.
- R12: After reset, `iir_o` = 0x01, `irq_o` = 0 and `ier_o` = 0, and the pending flag and the sticky flags are all clear.
- R13: A change on any input is visible on `iir_o` and `irq_o` after exactly one rising clock edge, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ier_we_i | input | 1 | Interrupt-enable write strobe |
| ier_wdata_i | input | 8 | Interrupt-enable write data |
| thr_we_i | input | 1 | Holding-register write pulse |
| tx_drain_i | input | 1 | Transmitter drained pulse |
| thre_i | input | 1 | Holding register empty (level) |
| iir_rd_i | input | 1 | Identification-byte read pulse |
| lsr_rd_i | input | 1 | Line-status read pulse |
| ovr_set_i | input | 1 | Overrun event pulse |
| brk_set_i | input | 1 | Break event pulse |
| parity_err_i | input | 1 | Parity error (level) |
| frame_err_i | input | 1 | Framing error (level) |
| rx_timeout_i | input | 1 | Receive timeout flag |
| data_ready_i | input | 1 | Receive data ready |
| fifo_en_i | input | 1 | FIFO mode enable |
| rx_count_i | input | CNT_W | Receive FIFO fill count |
| rx_trig_i | input | CNT_W | Receive trigger level |
| msr_delta_i | input | 4 | Modem-status delta bits |
| ier_o | output | 4 | Stored interrupt-enable value |
| iir_o | output | 8 | Interrupt identification byte |
| irq_o | output | 1 | Interrupt request line |

## Verification
A corrupt pending flag shows up as a wrong 0x2 code one clock after the event that should have changed it. Such an error hides whenever a higher source is active, so the checks drop the higher sources afterwards to bring it out. A sticky overrun or break flag that clears wrongly flips the identification code between 0x6 and the next lower source in the cycle after the line-status read. A fault in the priority encoder appears at once as a lower code while a higher source is active. The checks hold several sources active at a time so that each rank is compared with the one below it.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int unsigned NSRC = 5;

  typedef enum logic [3:0] {
    IID_MODEM = 4'h0,
    IID_NONE  = 4'h1,
    IID_THRE  = 4'h2,
    IID_RXD   = 4'h4,
    IID_LINE  = 4'h6,
    IID_TMO   = 4'hC
  } iid_e;

  // index 0 is the highest priority
  function automatic iid_e src_code(input int unsigned idx);
    case (idx)
      0:       return IID_LINE;
      1:       return IID_TMO;
      2:       return IID_RXD;
      3:       return IID_THRE;
      default: return IID_MODEM;
    endcase
  endfunction
endpackage

// File: rtl/uart_irq_state.sv
module uart_irq_state (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ier_we_i,
  input  logic [3:0] ier_wdata_i,
  input  logic       thr_we_i,
  input  logic       tx_drain_i,
  input  logic       thre_i,
  input  logic       iir_rd_i,
  input  logic       thre_shown_i,
  input  logic       lsr_rd_i,
  input  logic       ovr_set_i,
  input  logic       brk_set_i,
  output logic [3:0] ier_q_o,
  output logic [3:0] ier_d_o,
  output logic       pend_d_o,
  output logic       ovr_d_o,
  output logic       brk_d_o
);
  logic [3:0] ier_q;
  logic       pend_q, ovr_q, brk_q;

  always_comb begin
    ier_d_o = ier_we_i ? ier_wdata_i : ier_q;

    if (thr_we_i)                              pend_d_o = 1'b0;
    else if (tx_drain_i || (ier_we_i && thre_i)) pend_d_o = 1'b1;
    else if (iir_rd_i && thre_shown_i)         pend_d_o = 1'b0;
    else                                       pend_d_o = pend_q;

    ovr_d_o = ovr_set_i | (ovr_q & ~lsr_rd_i);
    brk_d_o = brk_set_i | (brk_q & ~lsr_rd_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ier_q  <= '0;
      pend_q <= 1'b0;
      ovr_q  <= 1'b0;
      brk_q  <= 1'b0;
    end else begin
      ier_q  <= ier_d_o;
      pend_q <= pend_d_o;
      ovr_q  <= ovr_d_o;
      brk_q  <= brk_d_o;
    end
  end

  assign ier_q_o = ier_q;
endmodule

// File: rtl/uart_irq_req.sv
module uart_irq_req
  import uart_irq_pkg::*;
#(
  parameter int unsigned CNT_W = 5
) (
  input  logic [3:0]       ier_i,
  input  logic             pend_i,
  input  logic             ovr_i,
  input  logic             brk_i,
  input  logic             parity_err_i,
  input  logic             frame_err_i,
  input  logic             rx_timeout_i,
  input  logic             data_ready_i,
  input  logic             fifo_en_i,
  input  logic [CNT_W-1:0] rx_count_i,
  input  logic [CNT_W-1:0] rx_trig_i,
  input  logic [3:0]       msr_delta_i,
  output logic [NSRC-1:0]  req_o
);
  logic at_trig;
  assign at_trig = (rx_count_i >= rx_trig_i);

  always_comb begin
    req_o[0] = ier_i[2] & (ovr_i | parity_err_i | frame_err_i | brk_i);
    req_o[1] = ier_i[0] & rx_timeout_i;
    req_o[2] = ier_i[0] & data_ready_i & (~fifo_en_i | at_trig);
    req_o[3] = ier_i[1] & pend_i;
    req_o[4] = ier_i[3] & (|msr_delta_i);
  end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  logic [NSRC-1:0] req_i,
  output iid_e            iid_o
);
  always_comb begin
    iid_o = IID_NONE;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req_i[i]) iid_o = src_code(i);
    end
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ier_we_i,
  input  logic [7:0]       ier_wdata_i,
  input  logic             thr_we_i,
  input  logic             tx_drain_i,
  input  logic             thre_i,
  input  logic             iir_rd_i,
  input  logic             lsr_rd_i,
  input  logic             ovr_set_i,
  input  logic             brk_set_i,
  input  logic             parity_err_i,
  input  logic             frame_err_i,
  input  logic             rx_timeout_i,
  input  logic             data_ready_i,
  input  logic             fifo_en_i,
  input  logic [CNT_W-1:0] rx_count_i,
  input  logic [CNT_W-1:0] rx_trig_i,
  input  logic [3:0]       msr_delta_i,
  output logic [3:0]       ier_o,
  output logic [7:0]       iir_o,
  output logic             irq_o
);
  logic [3:0]      ier_d;
  logic            pend_d, ovr_d, brk_d;
  logic [NSRC-1:0] req;
  iid_e            iid_d;
  logic [7:0]      iir_q;
  logic            irq_q;
  logic            unused_wdata_hi;

  assign unused_wdata_hi = ^ier_wdata_i[7:4];

  uart_irq_state u_state (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ier_we_i     (ier_we_i),
    .ier_wdata_i  (ier_wdata_i[3:0]),
    .thr_we_i     (thr_we_i),
    .tx_drain_i   (tx_drain_i),
    .thre_i       (thre_i),
    .iir_rd_i     (iir_rd_i),
    .thre_shown_i (iir_q[3:0] == IID_THRE),
    .lsr_rd_i     (lsr_rd_i),
    .ovr_set_i    (ovr_set_i),
    .brk_set_i    (brk_set_i),
    .ier_q_o      (ier_o),
    .ier_d_o      (ier_d),
    .pend_d_o     (pend_d),
    .ovr_d_o      (ovr_d),
    .brk_d_o      (brk_d)
  );

  uart_irq_req #(.CNT_W(CNT_W)) u_req (
    .ier_i        (ier_d),
    .pend_i       (pend_d),
    .ovr_i        (ovr_d),
    .brk_i        (brk_d),
    .parity_err_i (parity_err_i),
    .frame_err_i  (frame_err_i),
    .rx_timeout_i (rx_timeout_i),
    .data_ready_i (data_ready_i),
    .fifo_en_i    (fifo_en_i),
    .rx_count_i   (rx_count_i),
    .rx_trig_i    (rx_trig_i),
    .msr_delta_i  (msr_delta_i),
    .req_o        (req)
  );

  uart_irq_prio u_prio (
    .req_i (req),
    .iid_o (iid_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      iir_q <= {4'h0, IID_NONE};
      irq_q <= 1'b0;
    end else begin
      iir_q <= {{2{fifo_en_i}}, 2'b00, iid_d};
      irq_q <= (iid_d != IID_NONE);
    end
  end

  assign iir_o = iir_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ier_we_i,
  input logic [7:0] ier_wdata_i,
  input logic       thr_we_i,
  input logic       tx_drain_i,
  input logic       iir_rd_i,
  input logic       parity_err_i,
  input logic       fifo_en_i,
  input logic [3:0] ier_o,
  input logic [7:0] iir_o,
  input logic       irq_o
);
  a_r9_irq_matches_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (iir_o[3:0] != 4'h1));

  a_r5_thr_write_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thr_we_i |=> iir_o[3:0] != 4'h2);

  a_r6_read_clears_shown: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iir_rd_i && iir_o[3:0] == 4'h2 && !tx_drain_i && !ier_we_i) |=> iir_o[3:0] != 4'h2);

  a_r2_parity_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (parity_err_i && ier_o[2] && !ier_we_i) |=> iir_o[3:0] == 4'h6);

  a_r8_fifo_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> iir_o[7:4] == {{2{$past(fifo_en_i)}}, 2'b00});

  a_r11_ier_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ier_we_i |=> ier_o == $past(ier_wdata_i[3:0]));

  a_r1_no_enable_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ier_o == 4'h0 && !ier_we_i) |=> !irq_o);
endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ier_we_i     (ier_we_i),
  .ier_wdata_i  (ier_wdata_i),
  .thr_we_i     (thr_we_i),
  .tx_drain_i   (tx_drain_i),
  .iir_rd_i     (iir_rd_i),
  .parity_err_i (parity_err_i),
  .fifo_en_i    (fifo_en_i),
  .ier_o        (ier_o),
  .iir_o        (iir_o),
  .irq_o        (irq_o)
);

// File: tb/uart_irq_ident_bench.sv
module uart_irq_ident_bench;
  localparam int CNT_W = 5;
  localparam int NVEC  = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ier_we = 0, thr_we = 0, tx_drain = 0, thre = 0, iir_rd = 0, lsr_rd = 0;
  logic ovr_set = 0, brk_set = 0, pe = 0, fe = 0, tmo = 0, dr = 0, fen = 0;
  logic [7:0] ier_wd = '0;
  logic [CNT_W-1:0] cnt = '0, trig = '0;
  logic [3:0] dlt = '0;
  logic [3:0] ier_q;
  logic [7:0] iir;
  logic irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_irq_ident #(.CNT_W(CNT_W)) u_uart_irq_ident (
    .clk_i(clk), .rst_ni(rst_n), .ier_we_i(ier_we), .ier_wdata_i(ier_wd),
    .thr_we_i(thr_we), .tx_drain_i(tx_drain), .thre_i(thre), .iir_rd_i(iir_rd),
    .lsr_rd_i(lsr_rd), .ovr_set_i(ovr_set), .brk_set_i(brk_set),
    .parity_err_i(pe), .frame_err_i(fe), .rx_timeout_i(tmo), .data_ready_i(dr),
    .fifo_en_i(fen), .rx_count_i(cnt), .rx_trig_i(trig), .msr_delta_i(dlt),
    .ier_o(ier_q), .iir_o(iir), .irq_o(irq)
  );

  // {ier[30:27], pe, fe, tmo, dr, fen, cnt[21:17], trig[16:12], dlt[11:8], exp_iir[7:0]}
  localparam logic [30:0] VEC [NVEC] = '{
    {4'h0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 5'd0, 5'd0, 4'hF, 8'h01}, // R1 nothing enabled
    {4'hF, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 5'd0, 5'd0, 4'hF, 8'h06}, // R1 R2 line on top
    {4'hF, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 5'd0, 5'd0, 4'hF, 8'h0C}, // R1 timeout next
    {4'hE, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 5'd0, 5'd0, 4'hF, 8'h00}, // R3 timeout masked by bit0
    {4'h1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 5'd3, 5'd4, 4'h0, 8'hC1}, // R4 below trigger
    {4'h1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 5'd4, 5'd4, 4'h0, 8'hC4}, // R4 at trigger
    {4'h1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 5'd8, 5'd4, 4'h0, 8'hC1}, // R4 needs data ready
    {4'h8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0, 5'd0, 4'h2, 8'h00}, // R7 modem delta
    {4'h4, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 5'd0, 5'd0, 4'h0, 8'hC6}, // R2 R8 framing
    {4'hB, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 5'd0, 5'd0, 4'h0, 8'h04}  // R2 masked, R4 rx shown
  };

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic chk_iir(input string req, input logic [7:0] exp);
    chk(req, iir, exp);
    chk({req, " R9 irq"}, {7'd0, irq}, {7'd0, exp[3:0] != 4'h1});
  endtask

  task automatic wr_ier(input logic [7:0] v);
    ier_we = 1; ier_wd = v;
    step();
    ier_we = 0;
  endtask

  task automatic pulse(ref logic s);
    s = 1;
    step();
    s = 0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R12 reset state
    chk_iir("R12 reset iir", 8'h01);
    chk("R12 reset ier", {4'h0, ier_q}, 8'h00);
    step();
    rst_n = 1;
    step();
    chk_iir("R12 after release", 8'h01);

    for (int i = 0; i < NVEC; i++) begin
      ier_we = 1; ier_wd = {4'h0, VEC[i][30:27]};
      pe = VEC[i][26]; fe = VEC[i][25]; tmo = VEC[i][24]; dr = VEC[i][23];
      fen = VEC[i][22]; cnt = VEC[i][21:17]; trig = VEC[i][16:12]; dlt = VEC[i][11:8];
      step();
      ier_we = 0;
      chk_iir($sformatf("R1 table vector %0d", i), VEC[i][7:0]);
    end
    pe = 0; fe = 0; tmo = 0; dr = 0; fen = 0; cnt = '0; trig = '0; dlt = '0;

    // R11 upper write bits dropped
    wr_ier(8'hF0);
    chk("R11 upper bits dropped", {4'h0, ier_q}, 8'h00);
    wr_ier(8'hA5);
    chk("R11 low nibble kept", {4'h0, ier_q}, 8'h05);

    // R5 pending set by IER write while THRE, R6 cleared by read of code 2
    thre = 1;
    wr_ier(8'h02);
    chk_iir("R5 ier write sets pending", 8'h02);
    pulse(iir_rd);
    chk_iir("R6 read of code 2 clears", 8'h01);
    thre = 0;
    pulse(tx_drain);
    chk_iir("R5 drain sets pending", 8'h02);
    pulse(thr_we);
    chk_iir("R5 thr write clears", 8'h01);
    tx_drain = 1; thr_we = 1;
    step();
    tx_drain = 0; thr_we = 0;
    chk_iir("R5 thr write beats drain", 8'h01);

    // R6 read showing another code keeps pending
    wr_ier(8'h03);
    dr = 1;
    pulse(tx_drain);
    chk_iir("R6 rx outranks pending", 8'h04);
    pulse(iir_rd);
    chk_iir("R6 read of code 4", 8'h04);
    dr = 0;
    step();
    chk_iir("R6 pending survived", 8'h02);
    pulse(thr_we);

    // R10 sticky overrun / break cleared by LSR read
    wr_ier(8'h04);
    pulse(ovr_set);
    chk_iir("R10 overrun sticky", 8'h06);
    step();
    chk_iir("R10 overrun held", 8'h06);
    pulse(lsr_rd);
    chk_iir("R10 lsr read clears overrun", 8'h01);
    pulse(brk_set);
    chk_iir("R10 break sticky", 8'h06);
    brk_set = 1; lsr_rd = 1;
    step();
    brk_set = 0; lsr_rd = 0;
    chk_iir("R10 set beats lsr read", 8'h06);
    pulse(lsr_rd);
    chk_iir("R10 lsr read clears break", 8'h01);
    pe = 1;
    pulse(lsr_rd);
    chk_iir("R10 parity level unaffected", 8'h06);
    pe = 0;
    step();

    // R13 one clock latency
    fen = 1; dlt = 4'h1;
    wr_ier(8'h08);
    chk_iir("R13 after one edge", 8'hC0);
    dlt = 4'h0; fen = 0;
    #1;
    chk_iir("R13 no change before edge", 8'hC0);
    step();
    chk_iir("R13 change after edge", 8'h01);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule